// File: doc/BRIEF.md
# Montgomery Ladder Point-Multiplication Sequencer

This block drives an external binary-field datapath through a full projective-coordinate scalar multiplication kP. It follows a Montgomery-ladder schedule. It holds no field values. It only issues commands, one at a time. Each command names a field operation, two source registers and a destination register in a nine-entry register file that sits outside the block. The block keeps a command on its outputs until the datapath pulses `op_done`, then moves to the next one.

After a `start` pulse, the block latches the scalar, whose top bit must be 1. It first sets up the two ladder points. Next it handles scalar bit KW-2 with a sequence of its own. It then walks bits KW-3 down to 0, issuing one 19-command ladder step per bit. It ends with the affine conversion, which includes one inversion request. When it finishes, affine x sits in X1 and affine y sits in X2.

Top module: `ladder_seq`

## Requirements
- R1: While reset is active and after it is released, `busy`, `cmd_valid` and `done` are 0 until a start is accepted.
- R2: A `start` pulse seen while idle is accepted. `busy` and `cmd_valid` are 1 from the next cycle on and stay equal. Opcodes are MUL=0, SQR=1, ADD=2, MOV=3, INV=4; SQR, MOV and INV read only source A and drive source B with 0. Register indices are x=0, y=1, b=2, X1=3, X2=4, Z1=5, Z2=6, T=7, U=8. The first four commands, written dst=op(a,b), are X1=MOV(x), Z2=SQR(x), X2=SQR(Z2), X2=ADD(X2,b).
- R3: A command stays unchanged on the outputs until `op_done` is sampled high with it. The following command appears in the next cycle. An `op_done` pulse while idle has no effect.
- R4: If bit KW-2 of the scalar is 1, these 16 commands follow: T=MOV(Z2), U=MUL(X1,Z2), Z1=ADD(U,X2), Z1=SQR(Z1), U=MUL(U,X2), X1=MUL(x,Z1), X1=ADD(X1,U), T=MOV(X2), U=SQR(Z2), U=SQR(U), U=MUL(U,b), X2=SQR(X2), X2=SQR(X2), X2=ADD(X2,U), U=MUL(T,Z2), Z2=SQR(U).
- R5: If bit KW-2 is 0, these 13 commands follow instead: T=MOV(Z2), U=MUL(X1,Z2), Z2=ADD(U,X2), Z2=SQR(Z2), U=MUL(X1,X2), U=MUL(U,T), X2=MUL(x,Z2), X2=ADD(X2,U), T=MOV(X1), X1=SQR(X1), X1=SQR(X1), X1=ADD(X1,b), Z1=SQR(T).
- R6: For each bit i from KW-3 down to 0, in that order, a 1 bit issues these 19 commands: T=MOV(Z1), U=MUL(X1,Z2), Z1=MUL(X2,Z1), Z1=ADD(Z1,U), Z1=SQR(Z1), U=MUL(U,X2), U=MUL(U,T), X1=MUL(x,Z1), X1=ADD(X1,U), T=MOV(X2), X2=SQR(X2), X2=SQR(X2), U=SQR(Z2), U=SQR(U), U=MUL(U,b), X2=ADD(X2,U), T=SQR(T), U=SQR(Z2), Z2=MUL(T,U).
- R7: A 0 bit in the ladder loop issues the same 19 commands with X1 and X2 exchanged and Z1 and Z2 exchanged in every field.
- R8: After the loop, these 19 commands follow: T=MUL(Z1,Z2), U=MUL(x,T), U=INV(U), Z2=MUL(x,Z2), X2=ADD(X2,Z2), Z2=MUL(Z2,U), Z2=MUL(Z2,X1), Z1=MUL(x,Z1), X1=ADD(X1,Z1), X1=MUL(X1,X2), X2=SQR(x), X2=ADD(X2,y), X2=MUL(X2,T), X1=ADD(X1,X2), X1=MUL(X1,U), X2=ADD(x,Z2), X1=MUL(X1,X2), X2=ADD(X1,y), X1=MOV(Z2).
- R9: In the cycle after the last command's `op_done`, `busy` and `cmd_valid` fall and `done` rises. `done` stays high until the next accepted start and is never high together with `busy`.
- R10: A `start` pulse while busy is ignored. The scalar on the input is not latched, and the command stream is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiplication when idle |
| scalar | input | KW | Scalar k, top bit set |
| op_done | input | 1 | One-cycle completion pulse from the datapath |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | Result ready, held until next start |
| cmd_valid | output | 1 | A command is presented |
| cmd_op | output | 3 | Field operation code |
| cmd_src_a | output | 4 | First source register index |
| cmd_src_b | output | 4 | Second source register index |
| cmd_dst | output | 4 | Destination register index |

## Verification
The bench targets the points where the schedule branches. It uses scalars whose second bit is 1 and scalars whose second bit is 0, because a design that picked the wrong special sequence would issue 13 commands where 16 are due, or the reverse. It also uses scalars with mixed loop bits, including all-ones and all-zeros tails, where a missing index swap shows up as X1 and Z1 where X2 and Z2 are due. It varies the datapath latency from zero to three idle cycles, which would expose a sequencer that advanced without `op_done` or skipped a command after a back-to-back pulse. It also sends a second start in mid-run, sends stray `op_done` pulses while idle, and restarts while `done` is high; a design mishandling any of these would relatch the scalar, wander off idle, or leave `done` stuck.

// File: rtl/ladder_seq.sv
module ladder_seq #(
  parameter int KW = 233
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] scalar,
  input  logic          op_done,
  output logic          busy,
  output logic          done,
  output logic          cmd_valid,
  output logic [2:0]    cmd_op,
  output logic [3:0]    cmd_src_a,
  output logic [3:0]    cmd_src_b,
  output logic [3:0]    cmd_dst
);
  localparam int CW = $clog2(KW);

  localparam logic [2:0] MUL = 3'd0, SQR = 3'd1, ADD = 3'd2, MOV = 3'd3, INV = 3'd4;
  localparam logic [3:0] RX = 4'd0, RY = 4'd1, RB = 4'd2, X1 = 4'd3, X2 = 4'd4,
                         Z1 = 4'd5, Z2 = 4'd6, RT = 4'd7, RU = 4'd8;

  typedef enum logic [2:0] {IDLE, INIT, SECOND, LOOP, FIN} ph_t;

  ph_t           ph;
  logic [4:0]    step;
  logic [KW-1:0] k_sh;
  logic [CW-1:0] left;
  logic          done_r;
  logic          kbit;
  logic [14:0]   uop;
  logic [4:0]    len;
  logic          last;

  function automatic logic [14:0] c(logic [2:0] o, logic [3:0] a, logic [3:0] b, logic [3:0] d);
    return {o, a, b, d};
  endfunction

  function automatic logic [3:0] sw(logic [3:0] r);
    case (r)
      X1: return X2;
      X2: return X1;
      Z1: return Z2;
      Z2: return Z1;
      default: return r;
    endcase
  endfunction

  function automatic logic [14:0] code(ph_t p, logic [4:0] s, logic kb);
    logic [14:0] r;
    r = '0;
    case (p)
      INIT: case (s)
        5'd0: r = c(MOV, RX, RX, X1);
        5'd1: r = c(SQR, RX, RX, Z2);
        5'd2: r = c(SQR, Z2, RX, X2);
        default: r = c(ADD, X2, RB, X2);
      endcase
      SECOND: if (kb) case (s)
        5'd0:  r = c(MOV, Z2, RX, RT);
        5'd1:  r = c(MUL, X1, Z2, RU);
        5'd2:  r = c(ADD, RU, X2, Z1);
        5'd3:  r = c(SQR, Z1, RX, Z1);
        5'd4:  r = c(MUL, RU, X2, RU);
        5'd5:  r = c(MUL, RX, Z1, X1);
        5'd6:  r = c(ADD, X1, RU, X1);
        5'd7:  r = c(MOV, X2, RX, RT);
        5'd8:  r = c(SQR, Z2, RX, RU);
        5'd9:  r = c(SQR, RU, RX, RU);
        5'd10: r = c(MUL, RU, RB, RU);
        5'd11: r = c(SQR, X2, RX, X2);
        5'd12: r = c(SQR, X2, RX, X2);
        5'd13: r = c(ADD, X2, RU, X2);
        5'd14: r = c(MUL, RT, Z2, RU);
        default: r = c(SQR, RU, RX, Z2);
      endcase else case (s)
        5'd0:  r = c(MOV, Z2, RX, RT);
        5'd1:  r = c(MUL, X1, Z2, RU);
        5'd2:  r = c(ADD, RU, X2, Z2);
        5'd3:  r = c(SQR, Z2, RX, Z2);
        5'd4:  r = c(MUL, X1, X2, RU);
        5'd5:  r = c(MUL, RU, RT, RU);
        5'd6:  r = c(MUL, RX, Z2, X2);
        5'd7:  r = c(ADD, X2, RU, X2);
        5'd8:  r = c(MOV, X1, RX, RT);
        5'd9:  r = c(SQR, X1, RX, X1);
        5'd10: r = c(SQR, X1, RX, X1);
        5'd11: r = c(ADD, X1, RB, X1);
        default: r = c(SQR, RT, RX, Z1);
      endcase
      LOOP: begin
        case (s)
          5'd0:  r = c(MOV, Z1, RX, RT);
          5'd1:  r = c(MUL, X1, Z2, RU);
          5'd2:  r = c(MUL, X2, Z1, Z1);
          5'd3:  r = c(ADD, Z1, RU, Z1);
          5'd4:  r = c(SQR, Z1, RX, Z1);
          5'd5:  r = c(MUL, RU, X2, RU);
          5'd6:  r = c(MUL, RU, RT, RU);
          5'd7:  r = c(MUL, RX, Z1, X1);
          5'd8:  r = c(ADD, X1, RU, X1);
          5'd9:  r = c(MOV, X2, RX, RT);
          5'd10: r = c(SQR, X2, RX, X2);
          5'd11: r = c(SQR, X2, RX, X2);
          5'd12: r = c(SQR, Z2, RX, RU);
          5'd13: r = c(SQR, RU, RX, RU);
          5'd14: r = c(MUL, RU, RB, RU);
          5'd15: r = c(ADD, X2, RU, X2);
          5'd16: r = c(SQR, RT, RX, RT);
          5'd17: r = c(SQR, Z2, RX, RU);
          default: r = c(MUL, RT, RU, Z2);
        endcase
        if (!kb) r = {r[14:12], sw(r[11:8]), sw(r[7:4]), sw(r[3:0])};
      end
      FIN: case (s)
        5'd0:  r = c(MUL, Z1, Z2, RT);
        5'd1:  r = c(MUL, RX, RT, RU);
        5'd2:  r = c(INV, RU, RX, RU);
        5'd3:  r = c(MUL, RX, Z2, Z2);
        5'd4:  r = c(ADD, X2, Z2, X2);
        5'd5:  r = c(MUL, Z2, RU, Z2);
        5'd6:  r = c(MUL, Z2, X1, Z2);
        5'd7:  r = c(MUL, RX, Z1, Z1);
        5'd8:  r = c(ADD, X1, Z1, X1);
        5'd9:  r = c(MUL, X1, X2, X1);
        5'd10: r = c(SQR, RX, RX, X2);
        5'd11: r = c(ADD, X2, RY, X2);
        5'd12: r = c(MUL, X2, RT, X2);
        5'd13: r = c(ADD, X1, X2, X1);
        5'd14: r = c(MUL, X1, RU, X1);
        5'd15: r = c(ADD, RX, Z2, X2);
        5'd16: r = c(MUL, X1, X2, X1);
        5'd17: r = c(ADD, X1, RY, X2);
        default: r = c(MOV, Z2, RX, X1);
      endcase
      default: r = '0;
    endcase
    return r;
  endfunction

  assign kbit = k_sh[KW-2];
  assign uop  = code(ph, step, kbit);

  always_comb begin
    case (ph)
      INIT:    len = 5'd4;
      SECOND:  len = kbit ? 5'd16 : 5'd13;
      default: len = 5'd19;
    endcase
  end

  assign last = (step == len - 5'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= IDLE;
      step   <= '0;
      k_sh   <= '0;
      left   <= '0;
      done_r <= 1'b0;
    end else if (ph == IDLE) begin
      if (start) begin
        ph     <= INIT;
        step   <= '0;
        k_sh   <= scalar;
        done_r <= 1'b0;
      end
    end else if (op_done) begin
      if (!last) step <= step + 5'd1;
      else begin
        step <= '0;
        case (ph)
          INIT: ph <= SECOND;
          SECOND: begin
            ph   <= LOOP;
            k_sh <= k_sh << 1;
            left <= CW'(KW - 2);
          end
          LOOP: begin
            k_sh <= k_sh << 1;
            if (left == CW'(1)) ph <= FIN;
            else left <= left - CW'(1);
          end
          default: begin
            ph     <= IDLE;
            done_r <= 1'b1;
          end
        endcase
      end
    end
  end

  assign busy      = (ph != IDLE);
  assign cmd_valid = busy;
  assign done      = done_r;
  assign cmd_op    = uop[14:12];
  assign cmd_src_a = uop[11:8];
  assign cmd_src_b = uop[7:4];
  assign cmd_dst   = uop[3:0];
endmodule

// File: rtl/ladder_seq_chk.sv
module ladder_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       op_done,
  input logic       busy,
  input logic       done,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic [3:0] cmd_src_a,
  input logic [3:0] cmd_src_b,
  input logic [3:0] cmd_dst
);
  logic [14:0] cmd;
  assign cmd = {cmd_op, cmd_src_a, cmd_src_b, cmd_dst};

  assert_valid_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid == busy);

  assert_cmd_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op <= 3'd4 && cmd_src_a <= 4'd8 && cmd_src_b <= 4'd8 && cmd_dst <= 4'd8));

  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !op_done) |=> (cmd_valid && $stable(cmd)));

  assert_idle_done_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !done));

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !op_done) |=> (busy && $stable(cmd)));
endmodule

bind ladder_seq ladder_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_done(op_done), .busy(busy),
  .done(done), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_src_a(cmd_src_a),
  .cmd_src_b(cmd_src_b), .cmd_dst(cmd_dst)
);

// File: tb/tb_ladder_seq.sv
module tb_ladder_seq;
  localparam int KW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [KW-1:0] scalar = '0;
  logic          op_done = 1'b0;
  logic          busy, done, cmd_valid;
  logic [2:0]    cmd_op;
  logic [3:0]    cmd_src_a, cmd_src_b, cmd_dst;

  ladder_seq #(.KW(KW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .scalar(scalar), .op_done(op_done),
    .busy(busy), .done(done), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b), .cmd_dst(cmd_dst)
  );

  always #5 clk = ~clk;

  localparam int MUL = 0, SQR = 1, ADD = 2, MOV = 3, INV = 4;
  localparam int X = 0, Y = 1, B = 2, X1 = 3, X2 = 4, Z1 = 5, Z2 = 6, T = 7, U = 8;

  logic [14:0] q[$];
  string       tq[$];
  bit          exp_busy = 0, exp_done = 0;
  int          lat = 0, wcnt = 0, tests = 0, fails = 0, cycles = 0;
  bit          finished = 0;

  function automatic int sw(int r, bit s);
    if (!s) return r;
    if (r == X1) return X2;
    if (r == X2) return X1;
    if (r == Z1) return Z2;
    if (r == Z2) return Z1;
    return r;
  endfunction

  function automatic void p(string tag, int d, int op, int a, int b = 0, bit s = 0);
    q.push_back({3'(op), 4'(sw(a, s)), 4'(sw(b, s)), 4'(sw(d, s))});
    tq.push_back(tag);
  endfunction

  function automatic void build(logic [KW-1:0] k);
    q.delete(); tq.delete();
    p("R2", X1, MOV, X); p("R2", Z2, SQR, X); p("R2", X2, SQR, Z2); p("R2", X2, ADD, X2, B);
    if (k[KW-2]) begin
      p("R4", T, MOV, Z2);     p("R4", U, MUL, X1, Z2); p("R4", Z1, ADD, U, X2); p("R4", Z1, SQR, Z1);
      p("R4", U, MUL, U, X2);  p("R4", X1, MUL, X, Z1); p("R4", X1, ADD, X1, U); p("R4", T, MOV, X2);
      p("R4", U, SQR, Z2);     p("R4", U, SQR, U);      p("R4", U, MUL, U, B);   p("R4", X2, SQR, X2);
      p("R4", X2, SQR, X2);    p("R4", X2, ADD, X2, U); p("R4", U, MUL, T, Z2);  p("R4", Z2, SQR, U);
    end else begin
      p("R5", T, MOV, Z2);     p("R5", U, MUL, X1, Z2); p("R5", Z2, ADD, U, X2); p("R5", Z2, SQR, Z2);
      p("R5", U, MUL, X1, X2); p("R5", U, MUL, U, T);   p("R5", X2, MUL, X, Z2); p("R5", X2, ADD, X2, U);
      p("R5", T, MOV, X1);     p("R5", X1, SQR, X1);    p("R5", X1, SQR, X1);    p("R5", X1, ADD, X1, B);
      p("R5", Z1, SQR, T);
    end
    for (int i = KW - 3; i >= 0; i--) begin
      bit s = !k[i];
      string g = k[i] ? "R6" : "R7";
      p(g, T, MOV, Z1, 0, s);     p(g, U, MUL, X1, Z2, s);  p(g, Z1, MUL, X2, Z1, s); p(g, Z1, ADD, Z1, U, s);
      p(g, Z1, SQR, Z1, 0, s);    p(g, U, MUL, U, X2, s);   p(g, U, MUL, U, T, s);    p(g, X1, MUL, X, Z1, s);
      p(g, X1, ADD, X1, U, s);    p(g, T, MOV, X2, 0, s);   p(g, X2, SQR, X2, 0, s);  p(g, X2, SQR, X2, 0, s);
      p(g, U, SQR, Z2, 0, s);     p(g, U, SQR, U, 0, s);    p(g, U, MUL, U, B, s);    p(g, X2, ADD, X2, U, s);
      p(g, T, SQR, T, 0, s);      p(g, U, SQR, Z2, 0, s);   p(g, Z2, MUL, T, U, s);
    end
    p("R8", T, MUL, Z1, Z2);  p("R8", U, MUL, X, T);    p("R8", U, INV, U);       p("R8", Z2, MUL, X, Z2);
    p("R8", X2, ADD, X2, Z2); p("R8", Z2, MUL, Z2, U);  p("R8", Z2, MUL, Z2, X1); p("R8", Z1, MUL, X, Z1);
    p("R8", X1, ADD, X1, Z1); p("R8", X1, MUL, X1, X2); p("R8", X2, SQR, X);      p("R8", X2, ADD, X2, Y);
    p("R8", X2, MUL, X2, T);  p("R8", X1, ADD, X1, X2); p("R8", X1, MUL, X1, U);  p("R8", X2, ADD, X, Z2);
    p("R8", X1, MUL, X1, X2); p("R8", X2, ADD, X1, Y);  p("R8", X1, MOV, Z2);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("[TB] FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit s, logic [KW-1:0] k, bit stray, string tag);
    bit b0;
    @(negedge clk);
    check(busy == exp_busy, exp_busy ? "R2" : tag, "busy", busy, exp_busy);
    check(cmd_valid == exp_busy, exp_busy ? "R2" : tag, "cmd_valid", cmd_valid, exp_busy);
    check(done == exp_done, exp_busy ? "R9" : tag, "done", done, exp_done);
    if (exp_busy && q.size() > 0)
      check({cmd_op, cmd_src_a, cmd_src_b, cmd_dst} == q[0], s ? "R10" : tq[0], "command",
            {cmd_op, cmd_src_a, cmd_src_b, cmd_dst}, q[0]);
    b0 = exp_busy;
    start = s; scalar = k; op_done = 1'b0;
    if (b0) begin
      if (wcnt >= lat) begin
        op_done = 1'b1;
        void'(q.pop_front()); void'(tq.pop_front());
        wcnt = 0;
        lat = (lat + 1) % 4;
        if (q.size() == 0) begin exp_busy = 0; exp_done = 1; end
      end else wcnt++;
    end else if (stray) op_done = 1'b1;
    if (s && !b0) begin
      build(k); exp_busy = 1; exp_done = 0; wcnt = 0;
    end
  endtask

  task automatic run(logic [KW-1:0] k, bit poke);
    int n = 0;
    cyc(1, k, 0, "R2");
    while (exp_busy && !finished) begin
      n++;
      if (poke && n == 40) cyc(1, ~k, 0, "R10");
      else cyc(0, k, 0, "R3");
    end
    for (int i = 0; i < 3; i++) cyc(0, k, 0, "R9");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("[TB] FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) cyc(0, '0, 0, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(0, '0, 0, "R1");
    for (int i = 0; i < 4; i++) cyc(0, '0, 1, "R3");
    run(8'hC5, 0);
    run(8'hA3, 1);
    run(8'h80, 0);
    run(8'hFF, 1);
    for (int i = 0; i < 3; i++) cyc(0, '0, 1, "R3");
    run(8'h96, 0);
    run(8'hE0, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule